// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs transfers on an external memory bus with a 24-bit address, where two of the three byte lanes carry both address and data. Bits 7:0 of the address always leave on a dedicated lane. The middle lane carries address bits 15:8 and data bits 15:8. The upper lane carries address bits 23:16 and data bits 7:0. A requester pulses `req_i` while the controller is idle, with the address, write data, direction, size, a bus-width select and the wait configuration. The controller sequences an address phase, a data strobe phase and a completion clock, then reports `done_o` with any read data.

Each access is a 16-bit or an 8-bit bus cycle, chosen by the width select captured with the request. A word that a single cycle cannot carry is run as two byte cycles, low byte first. These are a word on the 8-bit bus, or a word at an odd address on the 16-bit bus. A programmable wait count lengthens the strobe. A ready input stretches it further. A hold handshake hands the bus to another master, but only between whole transfers. During hold every pin group is released through its output enable.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: An accepted request opens with exactly one address clock. In that clock `ale_o` is 1, `strobe_no` is 1, both multiplexed lanes are enabled, and {`ad_hi_o`,`ad_mid_o`,`a_lo_o`} equals the cycle's 24-bit address.
- R2: With `byte_mode_i`=0 captured, the bus is 16 bits wide. A full word puts bits 15:8 on the middle lane and bits 7:0 on the upper lane. A byte at an odd address uses the middle lane only. A byte at an even address uses the upper lane only. Lanes carry write data with their enable at 1, and are released (enable 0) for reads.
- R3: With `byte_mode_i`=1 captured, the bus is 8 bits wide. Data uses only the upper lane. The middle lane keeps driving address bits 15:8 through the strobe phase.
- R4: `bhe_no` is 0 throughout the address and strobe clocks of a cycle whose address is odd or that moves a full 16-bit word. It is 1 otherwise.
- R5: `rw_o` is 1 for a read and 0 for a write during a cycle, and it is 1 when no cycle runs.
- R6: The strobe (`strobe_no`=0) lasts 1+W clocks. W is 0 when `wait_en_ni`=1. When `wait_en_ni`=0, W is 1 for `wait_sel_i`=0 and 2 for `wait_sel_i`=1.
- R7: Each clock in which `rdy_ni` is 0 during the last counted strobe clock adds one strobe clock.
- R8: A word in 8-bit mode, or at an odd address in 16-bit mode, runs as two byte cycles at A and then A+1 (24-bit wrap). Each cycle has its own address phase. The byte at A fills read bits 7:0 and goes out from write bits 7:0.
- R9: `done_o` is 1 for exactly one clock, the clock after the last strobe clock. `rdata_o` then holds {byte at A+1, byte at A} for a word read and {8'h00, byte at A} for a byte read.
- R10: Hold is granted only from idle. While `hold_ni` is 0 and no transfer runs, `hlda_no` is 0 and `ctl_oe_o`, `ad_mid_oe_o` and `ad_hi_oe_o` are 0. Requests made during hold start nothing. Hold requested mid-transfer waits until after `done_o`.
- R11: After reset the bus is idle: `ale_o`=0, `strobe_no`=1, `rw_o`=1, `bhe_no`=1, `hlda_no`=1, `ctl_oe_o`=1, `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (taken only when idle and not holding) |
| addr_i | input | 24 | Transfer address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| byte_mode_i | input | 1 | Bus width select: 1 = 8-bit, 0 = 16-bit |
| wait_en_ni | input | 1 | 0 = insert wait clocks, 1 = none |
| wait_sel_i | input | 1 | Wait length: 0 = one clock, 1 = two clocks |
| rdy_ni | input | 1 | Ready, low stretches the strobe |
| hold_ni | input | 1 | Hold request, active low |
| ad_mid_i | input | 8 | Middle lane read value |
| ad_hi_i | input | 8 | Upper lane read value |
| a_lo_o | output | 8 | Address bits 7:0 |
| ad_mid_o | output | 8 | Middle lane drive value |
| ad_mid_oe_o | output | 1 | Middle lane output enable |
| ad_hi_o | output | 8 | Upper lane drive value |
| ad_hi_oe_o | output | 1 | Upper lane output enable |
| ctl_oe_o | output | 1 | Enable for the low address lane and control strobes |
| ale_o | output | 1 | Address latch enable |
| rw_o | output | 1 | 1 = read, 0 = write |
| bhe_no | output | 1 | Byte-high enable, active low |
| strobe_no | output | 1 | Data strobe, active low |
| hlda_no | output | 1 | Hold acknowledge, active low |
| rdata_o | output | 16 | Read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach is a hold request that arrives while an 8-bit-mode word is between its two byte cycles. The bus looks briefly quiet there, and the hold must still not be granted. The stimulus pulls `hold_ni` low in the clock right after the request is taken. It then follows the full two-cycle split, checks that acknowledge stays high until `done_o`, and checks that it falls two clocks later. Ready stretch is driven only in the clocks where the wait counter has run out. This makes each stalled clock add exactly one strobe clock, and the sweep covers it in both widths, all wait settings, both directions and both address parities.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ADDR,
    ST_DATA,
    ST_END
  } ebc_state_e;
endpackage

// File: rtl/ebc_wait_ctr.sv
module ebc_wait_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebc_lane_mux.sv
module ebc_lane_mux #(
  parameter int LANE_W = 8
) (
  input  logic                  addr_ph_i,
  input  logic                  data_ph_i,
  input  logic [3*LANE_W-1:0]   addr_i,
  input  logic [2*LANE_W-1:0]   wdata_i,
  input  logic [LANE_W-1:0]     wbyte_i,
  input  logic                  we_i,
  input  logic                  bm_i,
  input  logic                  full_i,
  input  logic [LANE_W-1:0]     mid_i,
  input  logic [LANE_W-1:0]     hi_i,
  output logic [LANE_W-1:0]     mid_o,
  output logic                  mid_oe_o,
  output logic [LANE_W-1:0]     hi_o,
  output logic                  hi_oe_o,
  output logic [LANE_W-1:0]     rd_byte_o,
  output logic [2*LANE_W-1:0]   rd_word_o
);
  always_comb begin
    mid_o     = addr_i[2*LANE_W-1:LANE_W];
    hi_o      = addr_i[3*LANE_W-1:2*LANE_W];
    mid_oe_o  = 1'b0;
    hi_oe_o   = 1'b0;
    rd_byte_o = hi_i;
    if (addr_ph_i) begin
      mid_oe_o = 1'b1;
      hi_oe_o  = 1'b1;
    end else if (data_ph_i) begin
      if (bm_i) begin
        // narrow bus: middle lane stays on address
        mid_oe_o = 1'b1;
        hi_o     = wbyte_i;
        hi_oe_o  = we_i;
      end else if (full_i) begin
        mid_o    = wdata_i[2*LANE_W-1:LANE_W];
        hi_o     = wdata_i[LANE_W-1:0];
        mid_oe_o = we_i;
        hi_oe_o  = we_i;
      end else if (addr_i[0]) begin
        mid_o     = wbyte_i;
        mid_oe_o  = we_i;
        rd_byte_o = mid_i;
      end else begin
        hi_o    = wbyte_i;
        hi_oe_o = we_i;
      end
    end
  end

  assign rd_word_o = {mid_i, hi_i};
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int WAIT_SHORT = 1,
  parameter int WAIT_LONG  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [3*LANE_W-1:0] addr_i,
  input  logic [2*LANE_W-1:0] wdata_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic                byte_mode_i,
  input  logic                wait_en_ni,
  input  logic                wait_sel_i,
  input  logic                rdy_ni,
  input  logic                hold_ni,
  input  logic [LANE_W-1:0]   ad_mid_i,
  input  logic [LANE_W-1:0]   ad_hi_i,
  output logic [LANE_W-1:0]   a_lo_o,
  output logic [LANE_W-1:0]   ad_mid_o,
  output logic                ad_mid_oe_o,
  output logic [LANE_W-1:0]   ad_hi_o,
  output logic                ad_hi_oe_o,
  output logic                ctl_oe_o,
  output logic                ale_o,
  output logic                rw_o,
  output logic                bhe_no,
  output logic                strobe_no,
  output logic                hlda_no,
  output logic [2*LANE_W-1:0] rdata_o,
  output logic                done_o
);
  localparam int ADDR_W = 3 * LANE_W;
  localparam int DATA_W = 2 * LANE_W;
  localparam int CNT_W  = $clog2(WAIT_LONG + 1);

  ebc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  wlen_q, wlen_d;
  logic              we_q, word_q, bm_q, split_q, phase_q;
  logic              accept, data_done, cnt_zero, full_word;
  logic              addr_ph, data_ph;
  logic [LANE_W-1:0] wbyte, rd_byte;
  logic [DATA_W-1:0] rd_word;

  assign addr_ph   = (state_q == ST_ADDR);
  assign data_ph   = (state_q == ST_DATA);
  assign accept    = (state_q == ST_IDLE) && hold_ni && req_i;
  assign data_done = data_ph && cnt_zero && rdy_ni;
  assign full_word = word_q && !split_q;
  assign wbyte     = phase_q ? wdata_q[DATA_W-1:LANE_W] : wdata_q[LANE_W-1:0];
  assign wlen_d    = wait_en_ni ? '0 :
                     (wait_sel_i ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wlen_q  <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      bm_q    <= 1'b0;
      split_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!hold_ni) begin
            state_q <= ST_HOLD;
          end else if (req_i) begin
            state_q <= ST_ADDR;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            we_q    <= we_i;
            word_q  <= word_i;
            bm_q    <= byte_mode_i;
            split_q <= word_i && (byte_mode_i || addr_i[0]);
            wlen_q  <= wlen_d;
            phase_q <= 1'b0;
          end
        end
        ST_HOLD: if (hold_ni) state_q <= ST_IDLE;
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (data_done) begin
            if (!we_q) begin
              if (full_word)     rdata_q <= rd_word;
              else if (!split_q) rdata_q <= {{LANE_W{1'b0}}, rd_byte};
              else if (!phase_q) rdata_q[LANE_W-1:0] <= rd_byte;
              else               rdata_q[DATA_W-1:LANE_W] <= rd_byte;
            end
            if (split_q && !phase_q) begin
              phase_q <= 1'b1;
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_ADDR;
            end else begin
              state_q <= ST_END;
            end
          end
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebc_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_ph),
    .load_val_i (wlen_q),
    .dec_i      (data_ph),
    .zero_o     (cnt_zero)
  );

  ebc_lane_mux #(.LANE_W(LANE_W)) u_lanes (
    .addr_ph_i (addr_ph),
    .data_ph_i (data_ph),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .wbyte_i   (wbyte),
    .we_i      (we_q),
    .bm_i      (bm_q),
    .full_i    (full_word),
    .mid_i     (ad_mid_i),
    .hi_i      (ad_hi_i),
    .mid_o     (ad_mid_o),
    .mid_oe_o  (ad_mid_oe_o),
    .hi_o      (ad_hi_o),
    .hi_oe_o   (ad_hi_oe_o),
    .rd_byte_o (rd_byte),
    .rd_word_o (rd_word)
  );

  assign a_lo_o    = addr_q[LANE_W-1:0];
  assign ctl_oe_o  = (state_q != ST_HOLD);
  assign hlda_no   = (state_q != ST_HOLD);
  assign ale_o     = addr_ph;
  assign strobe_no = !data_ph;
  assign rw_o      = !((addr_ph || data_ph) && we_q);
  assign bhe_no    = !((addr_ph || data_ph) && (addr_q[0] || full_word));
  assign done_o    = (state_q == ST_END);
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/ebc_bus_chk.sv
module ebc_bus_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic strobe_no,
  input logic rw_o,
  input logic bhe_no,
  input logic hlda_no,
  input logic ctl_oe_o,
  input logic ad_mid_oe_o,
  input logic ad_hi_oe_o,
  input logic done_o,
  input logic rdy_ni
);
  a_r1_ale_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r1_ale_lanes_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (strobe_no && ad_mid_oe_o && ad_hi_oe_o));
  a_r6_ale_then_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !strobe_no);
  a_r7_rdy_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no && !rdy_ni) |=> !strobe_no);
  a_r5_rw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> $stable(rw_o));
  a_r4_bhe_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bhe_no |-> (ale_o || !strobe_no));
  a_r9_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_no) |-> (done_o || ale_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hlda_no |-> (!ctl_oe_o && !ad_mid_oe_o && !ad_hi_oe_o));
  a_r10_hold_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_no) |-> $past(strobe_no && !ale_o && !done_o));
endmodule

bind ebc_bus_ctrl ebc_bus_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_o       (ale_o),
  .strobe_no   (strobe_no),
  .rw_o        (rw_o),
  .bhe_no      (bhe_no),
  .hlda_no     (hlda_no),
  .ctl_oe_o    (ctl_oe_o),
  .ad_mid_oe_o (ad_mid_oe_o),
  .ad_hi_oe_o  (ad_hi_oe_o),
  .done_o      (done_o),
  .rdy_ni      (rdy_ni)
);

// File: tb/tb_ebc_bus_ctrl.sv
module tb_ebc_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0, word_i = 1'b0, byte_mode_i = 1'b0;
  logic        wait_en_ni = 1'b1, wait_sel_i = 1'b0;
  logic        rdy_ni = 1'b1, hold_ni = 1'b1;
  logic [7:0]  ad_mid_i = '0, ad_hi_i = '0;
  logic [7:0]  a_lo_o, ad_mid_o, ad_hi_o;
  logic        ad_mid_oe_o, ad_hi_oe_o, ctl_oe_o, ale_o, rw_o, bhe_no;
  logic        strobe_no, hlda_no, done_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;

  ebc_bus_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] a, input logic [15:0] wd, input bit we,
                      input bit word, input bit bm, input bit wen_n,
                      input bit wsel, input int stall, input bit hold_mid);
    int w, subs, exp_idx, sub, j, done_idx;
    int dc[2];
    bit split, full;
    logic [23:0] sa;
    logic [7:0]  wb;
    w     = wen_n ? 0 : (wsel ? 2 : 1);
    split = word && (bm || a[0]);
    full  = word && !split;
    subs  = split ? 2 : 1;
    exp_idx = subs * (2 + w) + stall + 1;
    sub = -1; j = 0; done_idx = -1; dc[0] = 0; dc[1] = 0; sa = a;
    @(negedge clk_i);
    addr_i = a; wdata_i = wd; we_i = we; word_i = word; byte_mode_i = bm;
    wait_en_ni = wen_n; wait_sel_i = wsel; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    if (hold_mid) hold_ni = 1'b0;
    for (int idx = 1; idx <= 40; idx++) begin
      if (hold_mid) chk(hlda_no == 1'b1, "R10 no hold mid transfer", 32'(hlda_no), 1);
      if (ale_o) begin
        sub++;
        sa = {ad_hi_o, ad_mid_o, a_lo_o};
        chk(sa == a + 24'(sub), "R1 address phase lanes", 32'(sa), 32'(a + 24'(sub)));
        chk(ad_mid_oe_o && ad_hi_oe_o, "R1 lanes enabled",
            32'({ad_mid_oe_o, ad_hi_oe_o}), 32'h3);
        chk(bhe_no == !(sa[0] || full), "R4 bhe in address phase", 32'(bhe_no),
            32'(!(sa[0] || full)));
        j = 0;
      end
      if (!strobe_no) begin
        rdy_ni = !(sub == 0 && j >= w && j < w + stall);
        if (bm) begin ad_hi_i = mem(sa); ad_mid_i = 8'hEE; end
        else if (sa[0]) begin ad_mid_i = mem(sa); ad_hi_i = 8'hEE; end
        else begin ad_hi_i = mem(sa); ad_mid_i = mem(sa + 24'd1); end
        wb = (sub == 1) ? wd[15:8] : wd[7:0];
        chk(rw_o == !we, "R5 rw level", 32'(rw_o), 32'(!we));
        chk(bhe_no == !(sa[0] || full), "R4 bhe in strobe", 32'(bhe_no),
            32'(!(sa[0] || full)));
        if (bm) begin
          chk(ad_mid_oe_o && ad_mid_o == sa[15:8], "R3 middle lane keeps address",
              32'({ad_mid_oe_o, ad_mid_o}), 32'({1'b1, sa[15:8]}));
          chk(ad_hi_oe_o == we && (!we || ad_hi_o == wb), "R3 upper lane data",
              32'({ad_hi_oe_o, ad_hi_o}), 32'({we, wb}));
        end else if (full) begin
          chk(ad_mid_oe_o == we && ad_hi_oe_o == we &&
              (!we || {ad_mid_o, ad_hi_o} == wd), "R2 full word lanes",
              32'({ad_mid_oe_o, ad_hi_oe_o, ad_mid_o, ad_hi_o}), 32'({we, we, wd}));
        end else if (sa[0]) begin
          chk(ad_mid_oe_o == we && !ad_hi_oe_o && (!we || ad_mid_o == wb),
              "R2 odd byte on middle lane",
              32'({ad_mid_oe_o, ad_hi_oe_o, ad_mid_o}), 32'({we, 1'b0, wb}));
        end else begin
          chk(ad_hi_oe_o == we && !ad_mid_oe_o && (!we || ad_hi_o == wb),
              "R2 even byte on upper lane",
              32'({ad_hi_oe_o, ad_mid_oe_o, ad_hi_o}), 32'({we, 1'b0, wb}));
        end
        if (sub >= 0 && sub < 2) dc[sub]++;
        j++;
      end else begin
        rdy_ni = 1'b1;
      end
      if (done_o) begin done_idx = idx; break; end
      @(negedge clk_i);
    end
    rdy_ni = 1'b1;
    chk(done_idx == exp_idx, "R9 done timing", 32'(done_idx), 32'(exp_idx));
    chk(sub + 1 == subs, "R8 number of byte cycles", 32'(sub + 1), 32'(subs));
    chk(dc[0] == 1 + w + stall, "R6 R7 strobe length", 32'(dc[0]), 32'(1 + w + stall));
    if (split) chk(dc[1] == 1 + w, "R8 R6 second strobe length", 32'(dc[1]), 32'(1 + w));
    if (!we) begin
      logic [15:0] er;
      er = word ? {mem(a + 24'd1), mem(a)} : {8'h00, mem(a)};
      chk(rdata_o == er, "R9 R8 read data", 32'(rdata_o), 32'(er));
    end
    @(negedge clk_i);
    chk(!done_o, "R9 done single clock", 32'(done_o), 0);
    if (hold_mid) begin
      chk(hlda_no == 1'b1, "R10 idle clock before hold", 32'(hlda_no), 1);
      @(negedge clk_i);
      chk(!hlda_no && !ctl_oe_o, "R10 hold after transfer",
          32'({hlda_no, ctl_oe_o}), 0);
      hold_ni = 1'b1;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    logic [23:0] a;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk(!ale_o && strobe_no && rw_o && bhe_no && hlda_no && ctl_oe_o && !done_o,
        "R11 idle after reset",
        32'({ale_o, strobe_no, rw_o, bhe_no, hlda_no, ctl_oe_o, done_o}), 32'h3E);

    k = 0;
    for (int bm = 0; bm < 2; bm++)
      for (int wn = 0; wn < 2; wn++)
        for (int ws = 0; ws < 2; ws++)
          for (int we = 0; we < 2; we++)
            for (int wd = 0; wd < 2; wd++)
              for (int od = 0; od < 2; od++)
                for (int st = 0; st < 2; st++) begin
                  a = (24'hA53C10 + 24'(k) * 24'h010204) | 24'(od);
                  xfer(a, 16'h1234 ^ 16'(k * 16'h0F1E), we[0], wd[0], bm[0],
                       wn[0], ws[0], st * 2, 1'b0);
                  k++;
                end

    // R8 wrap of the second byte address
    xfer(24'hFFFFFF, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    xfer(24'hFFFFFF, 16'hC0DE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b0);

    // R10 hold from idle, requests ignored while held
    @(negedge clk_i);
    hold_ni = 1'b0;
    @(negedge clk_i);
    chk(!hlda_no && !ctl_oe_o && !ad_mid_oe_o && !ad_hi_oe_o, "R10 bus released",
        32'({hlda_no, ctl_oe_o, ad_mid_oe_o, ad_hi_oe_o}), 0);
    addr_i = 24'h123456; we_i = 1'b1; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!ale_o && !done_o && strobe_no, "R10 request ignored in hold",
          32'({ale_o, done_o, strobe_no}), 32'h1);
    end
    hold_ni = 1'b1;
    @(negedge clk_i);
    chk(hlda_no && ctl_oe_o, "R10 hold ends", 32'({hlda_no, ctl_oe_o}), 32'h3);
    chk(!ale_o, "R10 no late start from held request", 32'(ale_o), 0);

    // R10 hold raised inside a split word, and in a 16-bit cycle
    xfer(24'h400010, 16'h55AA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b1);
    xfer(24'h400021, 16'h6699, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1);
    xfer(24'h400030, 16'h7788, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule